// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Controller

This block is the device-side command logic of a serial flash behind an SPI slave port. It accepts frames in SPI mode 0 or mode 3, decodes three commands (set write enable, erase the whole array, read status) and keeps a write-enable latch and a busy flag. The block-protect setting comes from the rest of the device as a 3-bit input. All SPI pins are brought into the system clock domain, so SCK must run well below the system clock.

An erase runs only when four conditions hold. The erase frame must end exactly after its eighth bit. The write-enable latch must be set. All protect bits must be zero. No earlier erase may still be running. The erase starts when chip select is released. The block then raises a clear strobe toward the memory array and holds it until the array acknowledges. It reports busy in the status byte for at least a parameterised number of system clocks, and until the acknowledge arrives. A host reads status at any time, including during the erase, to poll for completion.

Top module: `flash_bulk_erase`

## Requirements
- R1: While cs_ni is low, si_i is sampled on each rising SCK edge, most significant bit first. The first eight bits form the opcode: 0x06 sets write enable, 0xC7 erases the whole array, 0x05 reads status. Both SCK idle levels (mode 0 low, mode 3 high) are accepted.
- R2: Opcode 0x06 sets the write-enable latch only when cs_ni rises after exactly eight SCK rising edges. A frame of 7 or 9 bits leaves the latch unchanged.
- R3: The status byte holds busy in bit 0 and the write-enable latch in bit 1. Bits 4:2 mirror bp_i[2:0], and bits 7:5 read 0. After opcode 0x05, the byte is driven on so_o MSB first, one bit per falling SCK edge, and repeats for as long as cs_ni stays low. so_oe_o is low during command bits and while cs_ni is high.
- R4: A valid erase (opcode 0xC7, exactly eight bits, latch set, bp_i zero, not busy) starts when cs_ni rises. Busy then reads 1 and erase_o goes high.
- R5: An erase frame received while bp_i is nonzero is ignored. erase_o stays low, busy stays 0, and the write-enable latch keeps its value.
- R6: An erase frame received while the write-enable latch is clear is ignored.
- R7: An erase frame that ends after 7 or 9 bits is ignored, and the write-enable latch keeps its value.
- R8: The write-enable latch reads 0 from the first cycle of an accepted erase.
- R9: erase_o stays high until erase_done_i is seen. Busy stays 1 for at least ERASE_CYCLES system clocks, and until the acknowledge, and then returns to 0.
- R10: While busy, opcode 0x06 and opcode 0xC7 have no effect, and read status still works.
- R11: After reset, busy and the write-enable latch are 0, and erase_o and so_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data from host |
| so_o | output | 1 | SPI serial data to host |
| so_oe_o | output | 1 | Output enable for so_o (high-impedance when low) |
| bp_i | input | 3 | Block-protect bits, reported in status bits 4:2 |
| erase_o | output | 1 | Array clear strobe, held until acknowledged |
| erase_done_i | input | 1 | Array acknowledge that the clear has finished |

## Verification
Some properties are checked on every cycle:
- The clear strobe only appears while busy, and it holds until acknowledged.
- Each erase starts on a chip-select release, with the protect bits zero and the latch already dropped.
- The latch only rises at a frame end while idle.
- The output enable falls once chip select is high.
- Busy never lasts fewer than the configured cycles.

The bench scenarios cover what a property cannot see. They decode whole frames: exact bit counts, the status byte layout seen serially in both clock modes, and repeated status bytes. They show that ignored commands leave the status unchanged, and that busy tracks both an early and a late array acknowledge.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned CMD_BITS = 8;

  localparam logic [CMD_BITS-1:0] OP_WREN = 8'h06;
  localparam logic [CMD_BITS-1:0] OP_BE   = 8'hC7;
  localparam logic [CMD_BITS-1:0] OP_RDSR = 8'h05;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [2:0] rsvd;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } status_t;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fe_spi_frame.sv
module fe_spi_frame
  import fe_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_n_i,
  input  logic                sck_i,
  input  logic                si_i,
  input  logic [CMD_BITS-1:0] status_i,
  output logic                frame_end_o,
  output logic                exact_o,
  output logic [CMD_BITS-1:0] cmd_o,
  output logic                so_o,
  output logic                so_oe_o
);
  localparam int unsigned CNT_W = $clog2(CMD_BITS + 2);
  localparam int unsigned OUT_W = $clog2(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CMD_BITS + 1);

  logic                sck_q, cs_q;
  logic                sck_rise, sck_fall;
  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_BITS-2:0] in_sr_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [CMD_BITS-2:0] out_sr_q;
  logic [OUT_W-1:0]    out_cnt_q;
  logic                so_q, oe_q;
  logic                rd_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
    end
  end

  assign sck_rise    = sck_i & ~sck_q & ~cs_n_i;
  assign sck_fall    = ~sck_i & sck_q & ~cs_n_i;
  assign frame_end_o = cs_n_i & ~cs_q;
  assign rd_active   = (cnt_q >= CNT_FULL) && (cmd_q == OP_RDSR);

  // command capture; count saturates one past a full opcode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      in_sr_q <= '0;
      cmd_q   <= '0;
    end else if (cs_n_i) begin
      cnt_q   <= '0;
      in_sr_q <= '0;
      cmd_q   <= '0;
    end else if (sck_rise) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_FULL) in_sr_q <= {in_sr_q[CMD_BITS-3:0], si_i};
      if (cnt_q == CNT_LAST) cmd_q <= {in_sr_q, si_i};
    end
  end

  // status shift-out on falling edges, reloaded at every byte boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr_q  <= '0;
      out_cnt_q <= '0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else if (cs_n_i) begin
      out_sr_q  <= '0;
      out_cnt_q <= '0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else if (sck_fall && rd_active) begin
      oe_q      <= 1'b1;
      out_cnt_q <= out_cnt_q + 1'b1;
      if (out_cnt_q == '0) begin
        so_q     <= status_i[CMD_BITS-1];
        out_sr_q <= status_i[CMD_BITS-2:0];
      end else begin
        so_q     <= out_sr_q[CMD_BITS-2];
        out_sr_q <= {out_sr_q[CMD_BITS-3:0], 1'b0};
      end
    end
  end

  assign exact_o = (cnt_q == CNT_FULL);
  assign cmd_o   = cmd_q;
  assign so_o    = so_q;
  assign so_oe_o = oe_q;
endmodule

// File: rtl/fe_erase_seq.sv
module fe_erase_seq
  import fe_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic erase_o
);
  localparam int unsigned      TMR_W    = $clog2(ERASE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(ERASE_CYCLES - 1);

  seq_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_ERASE;
            tmr_q   <= TMR_LOAD;
          end
        end
        SEQ_ERASE: begin
          if (!tmr_zero) tmr_q <= tmr_q - 1'b1;
          if (done_i) state_q <= tmr_zero ? SEQ_IDLE : SEQ_HOLD;
        end
        SEQ_HOLD: begin
          if (!tmr_zero) tmr_q <= tmr_q - 1'b1;
          else           state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != SEQ_IDLE);
  assign erase_o = (state_q == SEQ_ERASE);
endmodule

// File: rtl/flash_bulk_erase.sv
module flash_bulk_erase
  import fe_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 100000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  output logic       so_o,
  output logic       so_oe_o,
  input  logic [2:0] bp_i,
  output logic       erase_o,
  input  logic       erase_done_i
);
  logic                cs_n_s, sck_s, si_s;
  logic                frame_end, frame_exact;
  logic [CMD_BITS-1:0] frame_cmd;
  logic                seq_busy;
  logic                wel_q;
  logic                wren_ok, be_ok, cmd_window;
  status_t             status;

  fe_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   ({cs_n_s, sck_s, si_s})
  );

  always_comb begin
    status      = '0;
    status.bp   = bp_i;
    status.wel  = wel_q;
    status.wip  = seq_busy;
  end

  fe_spi_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_s),
    .sck_i      (sck_s),
    .si_i       (si_s),
    .status_i   (status),
    .frame_end_o(frame_end),
    .exact_o    (frame_exact),
    .cmd_o      (frame_cmd),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  // a command acts only on a clean 8-bit frame while idle
  assign cmd_window = frame_end & frame_exact & ~seq_busy;
  assign wren_ok    = cmd_window & (frame_cmd == OP_WREN);
  assign be_ok      = cmd_window & (frame_cmd == OP_BE) & wel_q & (bp_i == 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wel_q <= 1'b0;
    else if (be_ok)   wel_q <= 1'b0;
    else if (wren_ok) wel_q <= 1'b1;
  end

  fe_erase_seq #(
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(be_ok),
    .done_i (erase_done_i),
    .busy_o (seq_busy),
    .erase_o(erase_o)
  );
endmodule

// File: rtl/fe_erase_chk.sv
module fe_erase_chk #(
  parameter int unsigned ERASE_CYCLES = 100000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       wel_i,
  input logic       frame_end_i,
  input logic [2:0] bp_i,
  input logic       erase_i,
  input logic       done_i,
  input logic       cs_idle_i,
  input logic       so_oe_i
);
  localparam int unsigned TMR_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [TMR_W:0] MIN_RUN = (TMR_W + 1)'(ERASE_CYCLES);

  logic [TMR_W:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (!busy_i)      run_q <= '0;
    else if (run_q != '1)  run_q <= run_q + 1'b1;
  end

  p_erase_in_wip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |-> busy_i);

  p_erase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i && !done_i |=> erase_i);

  p_min_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> run_q >= MIN_RUN);

  p_wel_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !wel_i);

  p_start_on_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(frame_end_i));

  p_protect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(bp_i) == 3'b000);

  p_wel_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_i) |-> $past(frame_end_i) && !$past(busy_i));

  p_oe_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle_i |=> !so_oe_i);
endmodule

bind flash_bulk_erase fe_erase_chk #(
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (seq_busy),
  .wel_i      (wel_q),
  .frame_end_i(frame_end),
  .bp_i       (bp_i),
  .erase_i    (erase_o),
  .done_i     (erase_done_i),
  .cs_idle_i  (cs_n_s),
  .so_oe_i    (so_oe_o)
);

// File: tb/flash_bulk_erase_tb.sv
module flash_bulk_erase_tb;
  localparam int unsigned ERASE_CYCLES = 1000;
  localparam int HALF = 6;
  localparam logic [7:0] C_WREN = 8'h06;
  localparam logic [7:0] C_BE   = 8'hC7;
  localparam logic [7:0] C_RDSR = 8'h05;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  logic       so, so_oe;
  logic [2:0] bp = 3'b000;
  logic       erase;
  logic       done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int done_dly = 5;
  int erase_seen = 0;
  bit mon_en = 1'b0;
  logic [7:0] mon_sh = '0;
  int mon_n = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  flash_bulk_erase #(.ERASE_CYCLES(ERASE_CYCLES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .bp_i(bp), .erase_o(erase), .erase_done_i(done)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clk_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(bit m3, logic [7:0] op, int nbits, int rd_bytes);
    sck = m3;
    clk_wait(4);
    cs_n = 1'b0;
    clk_wait(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si  = (i < 8) ? op[7-i] : 1'b0;
      clk_wait(HALF);
      if (i == 3) chk(so_oe == 1'b0, "R3", "so_oe during command bits", {31'd0, so_oe}, 32'd0);
      sck = 1'b1;
      clk_wait(HALF);
    end
    if (rd_bytes > 0) begin
      mon_en = 1'b1;
      for (int i = 0; i < rd_bytes * 8; i++) begin
        sck = 1'b0;
        clk_wait(HALF);
        sck = 1'b1;
        clk_wait(HALF);
      end
    end
    if (!m3) begin
      sck = 1'b0;
      clk_wait(HALF);
    end
    cs_n = 1'b1;
    mon_en = 1'b0;
    clk_wait(8);
  endtask

  // driver side of the scoreboard: expected status bytes
  task automatic rdsr(bit m3, int nb, logic [7:0] exp, string req);
    for (int i = 0; i < nb; i++) begin
      exp_q.push_back(exp);
      req_q.push_back(req);
    end
    frame(m3, C_RDSR, 8, nb);
  endtask

  // monitor: host samples SO on rising SCK
  always @(posedge sck) begin
    if (mon_en) begin
      mon_sh = {mon_sh[6:0], so};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        chk(so_oe == 1'b1, "R3", "so_oe while reading status", {31'd0, so_oe}, 32'd1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected status byte", {24'd0, mon_sh}, 32'd0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          chk(mon_sh == e, r, "status byte", {24'd0, mon_sh}, {24'd0, e});
        end
      end
    end
  end

  // array model: acknowledges the clear after done_dly cycles
  initial begin
    forever begin
      @(posedge erase);
      erase_seen++;
      clk_wait(done_dly);
      chk(erase == 1'b1, "R9", "erase strobe held until ack", {31'd0, erase}, 32'd1);
      done = 1'b1;
      clk_wait(1);
      done = 1'b0;
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    clk_wait(3);
    rst_n = 1'b1;
    clk_wait(3);
    chk(erase == 1'b0, "R11", "erase_o after reset", {31'd0, erase}, 32'd0);
    chk(so_oe == 1'b0, "R11", "so_oe after reset", {31'd0, so_oe}, 32'd0);
    rdsr(1'b0, 1, 8'h00, "R11");

    // R6: erase without write enable
    frame(1'b0, C_BE, 8, 0);
    chk(erase_seen == 0, "R6", "erase without latch", erase_seen, 0);
    rdsr(1'b0, 1, 8'h00, "R6");

    // R2: bad-length write enable, then a good one (R1)
    frame(1'b0, C_WREN, 7, 0);
    rdsr(1'b0, 1, 8'h00, "R2");
    frame(1'b0, C_WREN, 9, 0);
    rdsr(1'b0, 1, 8'h00, "R2");
    frame(1'b0, C_WREN, 8, 0);
    rdsr(1'b0, 1, 8'h02, "R1");

    // R5: protected array
    bp = 3'b010;
    frame(1'b0, C_BE, 8, 0);
    chk(erase_seen == 0, "R5", "erase while protected", erase_seen, 0);
    rdsr(1'b0, 1, 8'h0A, "R5");
    bp = 3'b000;

    // R7: wrong frame lengths
    frame(1'b0, C_BE, 7, 0);
    rdsr(1'b0, 1, 8'h02, "R7");
    frame(1'b1, C_BE, 9, 0);
    rdsr(1'b0, 1, 8'h02, "R7");
    chk(erase_seen == 0, "R7", "erase after bad length", erase_seen, 0);

    // R3: mode 3 read, repeated byte
    rdsr(1'b1, 2, 8'h02, "R3");

    // R4/R8/R10: accepted erase, early ack
    done_dly = 5;
    frame(1'b1, C_BE, 8, 0);
    chk(erase_seen == 1, "R4", "erase started", erase_seen, 1);
    rdsr(1'b0, 1, 8'h01, "R8");
    frame(1'b0, C_WREN, 8, 0);
    rdsr(1'b0, 1, 8'h01, "R10");
    clk_wait(700);
    rdsr(1'b0, 1, 8'h00, "R9");

    // R9: late ack keeps strobe and busy
    done_dly = 1500;
    frame(1'b0, C_WREN, 8, 0);
    frame(1'b0, C_BE, 8, 0);
    chk(erase_seen == 2, "R4", "second erase started", erase_seen, 2);
    clk_wait(1100);
    chk(erase == 1'b1, "R9", "strobe waiting for ack", {31'd0, erase}, 32'd1);
    rdsr(1'b0, 1, 8'h01, "R9");
    clk_wait(400);
    chk(erase == 1'b0, "R9", "strobe after ack", {31'd0, erase}, 32'd0);
    rdsr(1'b0, 1, 8'h00, "R9");

    chk(exp_q.size() == 0, "R3", "status bytes outstanding", exp_q.size(), 0);
    report();
  end
endmodule